// File: doc/BRIEF.md
# Sound Level Threshold Detector

This block turns a stream of decimated PCM audio words into a coarse loudness figure and raises a latched alarm when that figure exceeds a programmable limit. Each accepted sample moves an exponential smoother one step toward the new input. The smoother's time constant is about a thousand samples.

A sample counter selects every N-th update, where N comes from a window-length input. At each selected update the smoothed amplitude is converted to an approximate decibel value with a fixed offset. The value is published with a one-cycle strobe and compared with the threshold. The alarm latches until an acknowledge pulse clears it.

The conversion uses a leading-one search and a 16-entry mantissa table followed by a constant multiply. It needs no divider and no iterative log unit. Levels and thresholds share one signed fixed-point format with a resolution of half a decibel.

Top module: `sound_level_alarm`

## Requirements
- R1: After reset, `level_o` is -512, `level_vld_o` and `alarm_o` are low, and both the smoother state and the sample counter are zero.
- R2: On every cycle with `pcm_vld_i` high, the smoother state `y` is updated. The state is signed fixed point with 10 fractional bits, and the update is `y <= y + ((pcm_i * 1024 - y) >>> 10)`, using an arithmetic shift. Without `pcm_vld_i` the state holds.
- R3: A measurement is taken on every `window_i`-th valid sample, and the sample counter then restarts from zero. A `window_i` of 0 behaves as 1.
- R4: The result of a measurement appears on `level_o` one clock after the sample that completed the window, together with a single-cycle `level_vld_o` pulse. `level_o` holds its value between measurements.
- R5: `level_o` approximates `20*log10(Y) - 26` dB to within 1.5 dB. Y is the integer part of the smoothed value (`y >>> 10`). The output is a signed 10-bit two's-complement number in half-dB units, so Y = 1 gives exactly -52.
- R6: When Y is below 1 (the smoothed value is below one, including zero and negative values), `level_o` is -512.
- R7: At each measurement, a level strictly greater than `thresh_i` sets `alarm_o` in the same cycle that `level_vld_o` is high. `thresh_i` uses the same units as `level_o`. A level equal to the threshold does not set the alarm.
- R8: `alarm_o` stays set until a cycle with `ack_i` high clears it. If a measurement that exceeds the threshold lands in the same cycle as the acknowledge, the alarm stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_vld_i | input | 1 | Sample strobe |
| pcm_i | input | 16 | Signed PCM sample |
| window_i | input | 16 | Samples per measurement |
| thresh_i | input | 10 | Signed alarm threshold, half-dB units |
| ack_i | input | 1 | Clears the latched alarm |
| level_o | output | 10 | Signed level, half-dB units |
| level_vld_o | output | 1 | One-cycle pulse when a new level is available |
| alarm_o | output | 1 | Latched alarm flag |

## Verification
The bench keeps an exact integer model of the smoother, so any error in the shift or the sign extension shows up as a growing level mismatch on loud or negative passages. A design that mishandles small signals is caught by two cases. A smoothed value between zero and one, or below zero, must report the floor of -512; a design that takes the log of that value reports an arbitrary level instead. A first sample of 1024 straight after reset must give exactly -52, and a smoother that did not start from zero gives something else.

The threshold test uses a level exactly equal to the limit. A design that compares with greater-or-equal raises a false alarm there. Windows of 0, 1 and several samples expose off-by-one errors in the counter as a strobe that comes one sample early or late.

An acknowledge that lands together with a loud measurement shows whether the clear wrongly takes priority over the set.

// File: rtl/sld_pkg.sv
package sld_pkg;

    // Mantissa width used by the log approximation table
    localparam int MANT_W = 4;

    // 16 * log2(1 + m/16), rounded to the nearest integer
    function automatic logic [MANT_W-1:0] mant_log2(input logic [MANT_W-1:0] m);
        logic [MANT_W-1:0] r;
        case (m)
            4'd0:  r = 4'd0;
            4'd1:  r = 4'd1;
            4'd2:  r = 4'd3;
            4'd3:  r = 4'd4;
            4'd4:  r = 4'd5;
            4'd5:  r = 4'd6;
            4'd6:  r = 4'd7;
            4'd7:  r = 4'd8;
            4'd8:  r = 4'd9;
            4'd9:  r = 4'd10;
            4'd10: r = 4'd11;
            4'd11: r = 4'd12;
            4'd12: r = 4'd13;
            4'd13: r = 4'd14;
            4'd14: r = 4'd15;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sld_smoother.sv
module sld_smoother #(
    parameter int PCM_W    = 16,
    parameter int FRAC_W   = 10,
    parameter int ALPHA_SH = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              vld_i,
    input  logic signed [PCM_W-1:0]           pcm_i,
    output logic signed [PCM_W+FRAC_W-1:0]    y_o
);
    localparam int ACC_W = PCM_W + FRAC_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] y;
    } sm_state_t;

    sm_state_t st_d, st_q;

    logic signed [ACC_W:0] x_ext;
    logic signed [ACC_W:0] y_ext;
    logic signed [ACC_W:0] diff;
    logic signed [ACC_W:0] step;
    logic signed [ACC_W:0] sum;

    always_comb begin
        st_d  = st_q;
        x_ext = $signed({pcm_i[PCM_W-1], pcm_i, {FRAC_W{1'b0}}});
        y_ext = $signed({st_q.y[ACC_W-1], st_q.y});
        diff  = x_ext - y_ext;
        step  = diff >>> ALPHA_SH;
        sum   = y_ext + step;
        if (vld_i) begin
            st_d.y = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_o = st_q.y;

endmodule

// File: rtl/sld_window.sv
module sld_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [CNT_W-1:0] window_i,
    output logic             meas_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             meas;
    } win_state_t;

    win_state_t st_d, st_q;

    logic [CNT_W:0] next_cnt;

    always_comb begin
        st_d      = st_q;
        st_d.meas = 1'b0;
        next_cnt  = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (vld_i) begin
            if (next_cnt >= {1'b0, window_i}) begin
                st_d.cnt  = '0;
                st_d.meas = 1'b1;
            end else begin
                st_d.cnt  = next_cnt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign meas_o = st_q.meas;

endmodule

// File: rtl/sld_log_db.sv
module sld_log_db
    import sld_pkg::*;
#(
    parameter int PCM_W    = 16,
    parameter int DB_W     = 10,
    parameter int DB_SCALE = 771,
    parameter int SCALE_SH = 10,
    parameter int DB_OFS2  = 52
) (
    input  logic signed [PCM_W-1:0] yint_i,
    output logic signed [DB_W-1:0]  level_o
);
    localparam int MAG_W  = PCM_W - 1;
    localparam int POS_W  = $clog2(MAG_W);
    localparam int LG_W   = POS_W + MANT_W;
    localparam int PROD_W = LG_W + 16;
    localparam logic signed [DB_W-1:0] DB_MIN = {1'b1, {(DB_W-1){1'b0}}};

    logic [MAG_W-1:0]  mag;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  sh;
    logic [MAG_W-1:0]  norm;
    logic [MANT_W-1:0] mant;
    logic [LG_W-1:0]   lg;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] half;
    logic signed [PROD_W:0] lvl_full;

    always_comb begin
        mag = yint_i[MAG_W-1:0];
        pos = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) pos = POS_W'(i);
        end
        sh   = POS_W'(MAG_W - 1) - pos;
        norm = mag << sh;
        mant = norm[MAG_W-2 -: MANT_W];
        lg   = {pos, mant_log2(mant)};
        prod = PROD_W'(lg) * PROD_W'(DB_SCALE) + PROD_W'(1 << (SCALE_SH - 1));
        half = prod >> SCALE_SH;
        lvl_full = $signed({1'b0, half}) - (PROD_W+1)'(DB_OFS2);
        if (yint_i[PCM_W-1] || (mag == '0)) begin
            level_o = DB_MIN;
        end else begin
            level_o = lvl_full[DB_W-1:0];
        end
    end

endmodule

// File: rtl/sound_level_alarm.sv
module sound_level_alarm #(
    parameter int PCM_W    = 16,
    parameter int FRAC_W   = 10,
    parameter int ALPHA_SH = 10,
    parameter int CNT_W    = 16,
    parameter int DB_W     = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pcm_vld_i,
    input  logic signed [PCM_W-1:0] pcm_i,
    input  logic [CNT_W-1:0]        window_i,
    input  logic signed [DB_W-1:0]  thresh_i,
    input  logic                    ack_i,
    output logic signed [DB_W-1:0]  level_o,
    output logic                    level_vld_o,
    output logic                    alarm_o
);
    localparam int ACC_W = PCM_W + FRAC_W;
    localparam logic signed [DB_W-1:0] DB_MIN = {1'b1, {(DB_W-1){1'b0}}};

    typedef struct packed {
        logic signed [DB_W-1:0] level;
        logic                   vld;
        logic                   alarm;
    } out_state_t;

    out_state_t st_d, st_q;

    logic signed [ACC_W-1:0] y;
    logic                    meas;
    logic signed [DB_W-1:0]  lvl_now;

    sld_smoother #(
        .PCM_W   (PCM_W),
        .FRAC_W  (FRAC_W),
        .ALPHA_SH(ALPHA_SH)
    ) u_smooth (
        .clk  (clk),
        .rst_n(rst_n),
        .vld_i(pcm_vld_i),
        .pcm_i(pcm_i),
        .y_o  (y)
    );

    sld_window #(
        .CNT_W(CNT_W)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (pcm_vld_i),
        .window_i(window_i),
        .meas_o  (meas)
    );

    sld_log_db #(
        .PCM_W(PCM_W),
        .DB_W (DB_W)
    ) u_log (
        .yint_i (y[ACC_W-1:FRAC_W]),
        .level_o(lvl_now)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = meas;
        if (ack_i) begin
            st_d.alarm = 1'b0;
        end
        if (meas) begin
            st_d.level = lvl_now;
            if (lvl_now > thresh_i) begin
                st_d.alarm = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= DB_MIN;
            st_q.vld   <= 1'b0;
            st_q.alarm <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o     = st_q.level;
    assign level_vld_o = st_q.vld;
    assign alarm_o     = st_q.alarm;

endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
    parameter int PCM_W = 16,
    parameter int CNT_W = 16,
    parameter int DB_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pcm_vld_i,
    input logic signed [DB_W-1:0]  thresh_i,
    input logic                    ack_i,
    input logic signed [DB_W-1:0]  level_o,
    input logic                    level_vld_o,
    input logic                    alarm_o
);
    // R4: a level pulse is always preceded by an accepted sample
    a_r4_pulse_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        level_vld_o |-> $past(pcm_vld_i, 2));

    // R4: the level holds between measurements
    a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !level_vld_o |-> $stable(level_o));

    // R7: a level above the threshold leaves the alarm set
    a_r7_alarm_on_exceed: assert property (@(posedge clk) disable iff (!rst_n)
        (level_vld_o && (level_o > $past(thresh_i))) |-> alarm_o);

    // R8: the alarm only rises with a measurement
    a_r8_rise_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> level_vld_o);

    // R8: an acknowledge without a measurement clears the alarm
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_i) && !level_vld_o) |-> !alarm_o);

endmodule

bind sound_level_alarm sld_checker #(
    .PCM_W(PCM_W),
    .CNT_W(CNT_W),
    .DB_W (DB_W)
) u_sld_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pcm_vld_i  (pcm_vld_i),
    .thresh_i   (thresh_i),
    .ack_i      (ack_i),
    .level_o    (level_o),
    .level_vld_o(level_vld_o),
    .alarm_o    (alarm_o)
);

// File: tb/tb_sound_level_alarm.sv
`timescale 1ns/1ps
module tb_sound_level_alarm;
    localparam int PCM_W = 16;
    localparam int CNT_W = 16;
    localparam int DB_W  = 10;
    localparam int DB_MIN = -512;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    pcm_vld_i = 1'b0;
    logic signed [PCM_W-1:0] pcm_i = '0;
    logic [CNT_W-1:0]        window_i = 16'd1;
    logic signed [DB_W-1:0]  thresh_i = '0;
    logic                    ack_i = 1'b0;
    logic signed [DB_W-1:0]  level_o;
    logic                    level_vld_o;
    logic                    alarm_o;

    int checks = 0;
    int failures = 0;

    longint y_m;
    int     cnt_m;
    bit     alarm_m;

    always #4 clk = ~clk;

    sound_level_alarm dut (
        .clk(clk), .rst_n(rst_n), .pcm_vld_i(pcm_vld_i), .pcm_i(pcm_i),
        .window_i(window_i), .thresh_i(thresh_i), .ack_i(ack_i),
        .level_o(level_o), .level_vld_o(level_vld_o), .alarm_o(alarm_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_level_exact(input longint y);
        longint yi = y >>> 10;
        if (yi < 1) return DB_MIN;
        return -9999;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pcm_vld_i = 1'b0;
        ack_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        y_m = 0;
        cnt_m = 0;
        alarm_m = 1'b0;
    endtask

    task automatic send(input int x, input bit ack_too, input int exact_exp);
        bit meas;
        longint yi;
        real ideal;
        int win_eff;
        @(negedge clk);
        pcm_vld_i = 1'b1;
        pcm_i = PCM_W'(x);
        @(negedge clk);
        pcm_vld_i = 1'b0;
        // R2 model of the smoother
        y_m = y_m + (((longint'(x) <<< 10) - y_m) >>> 10);
        win_eff = (window_i == 0) ? 1 : int'(window_i);
        cnt_m++;
        meas = (cnt_m >= win_eff);
        if (meas) cnt_m = 0;
        if (meas) begin
            ack_i = ack_too;
            @(negedge clk);
            ack_i = 1'b0;
            check("R3/R4 strobe on window end", level_vld_o, 1);
            yi = y_m >>> 10;
            if (exact_exp != -9999) begin
                check("R5 exact level", level_o, exact_exp);
            end else if (yi < 1) begin
                check("R6 floor level", level_o, DB_MIN);
            end else begin
                ideal = 2.0 * (20.0 * $log10(real'(yi)) - 26.0);
                checks++;
                if ((real'(level_o) - ideal > 3.0) || (ideal - real'(level_o) > 3.0)) begin
                    failures++;
                    $display("FAIL R5 level accuracy actual=%0d expected=%0.2f", level_o, ideal);
                end
            end
            // R7/R8 alarm model, set wins over acknowledge
            if (ack_too) alarm_m = 1'b0;
            if (level_o > thresh_i) alarm_m = 1'b1;
            check("R7/R8 alarm after measurement", alarm_o, alarm_m);
        end else begin
            check("R3 no strobe mid window", level_vld_o, 0);
            check("R8 alarm held", alarm_o, alarm_m);
        end
    endtask

    task automatic acknowledge();
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        alarm_m = 1'b0;
        check("R8 ack clears alarm", alarm_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        y_m = 0; cnt_m = 0; alarm_m = 1'b0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 level after reset", level_o, DB_MIN);
        check("R1 strobe after reset", level_vld_o, 0);
        check("R1 alarm after reset", alarm_o, 0);

        // R1/R2/R5: smoother starts at zero, Y=1 gives -52; -52 > -53 raises alarm
        window_i = 16'd1;
        thresh_i = -10'sd53;
        send(1024, 1'b0, -52);
        acknowledge();

        // R7: level equal to threshold does not alarm
        do_reset();
        thresh_i = -10'sd52;
        send(1024, 1'b0, -52);
        check("R7 equal does not alarm", alarm_o, 0);

        // R6: negative smoothed value reports floor
        do_reset();
        thresh_i = -10'sd100;
        send(-2000, 1'b0, DB_MIN);
        // R6: value between zero and one reports floor
        do_reset();
        send(500, 1'b0, DB_MIN);

        // R3: window of four, then window of zero behaves as one
        do_reset();
        window_i = 16'd4;
        thresh_i = 10'sd127;
        for (int i = 0; i < 4; i++) send(20000, 1'b0, -9999);
        window_i = 16'd0;
        send(20000, 1'b0, -9999);
        send(20000, 1'b0, -9999);

        // R8: set wins when ack coincides with an exceeding measurement
        do_reset();
        window_i = 16'd1;
        thresh_i = -10'sd60;
        send(1024, 1'b0, -52);
        send(1024, 1'b1, -9999);
        check("R8 set wins over ack", alarm_o, 1);
        acknowledge();

        // Random phases: R2 R3 R5 R6 R7
        do_reset();
        for (int ph = 0; ph < 12; ph++) begin
            int base;
            window_i = CNT_W'($urandom_range(1, 40));
            thresh_i = DB_W'(int'($urandom_range(0, 190)) - 60);
            base = int'($urandom_range(0, 36767)) - 4000;
            if (base > 32767) base = 32767;
            for (int s = 0; s < 400; s++) begin
                int x;
                x = base + int'($urandom_range(0, 1000)) - 500;
                if (x > 32767) x = 32767;
                if (x < -32768) x = -32768;
                send(x, ($urandom_range(0, 30) == 0), -9999);
            end
            if (alarm_m) acknowledge();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule